// File: doc/BRIEF.md
# Retirement Exception and Status Unit

This block watches the oldest entry of an out-of-order core's reorder buffer and decides, in the same cycle, whether that entry commits, whether it raises an interrupt, and whether the pipeline must be flushed. It also owns a small file of 32-bit special registers: the live status word, a saved copy of status, the cause word, the saved program counter, the saved delayed program counter, the trap data word, the sticky floating-point flag word and one plain general special register.

Each incoming cause bit is gated by the matching status bit, unless it is one of the always-enabled bits. Interrupts fall into two classes. A redo-class interrupt blocks the write of the faulting entry and saves its own PC fields and the status as it was before the cycle. A continue-class interrupt lets the entry complete its write and saves the following PC fields and the status as it is after that write.

The head entry is presented as a valid bit together with a buffer-empty flag. `retire` acts as the acceptance of that entry, so the buffer advances its head only when `retire` is high. The block never holds the entry back: there is no back-pressure beyond that one signal. `clear` tells the rest of the core to flush. All decisions are combinational from the inputs and the stored status. The register file updates on the rising clock edge. The register file can be inspected through a combinational read port.

Top module: `reu_top`

## Requirements
- R1: `mcause[i]` equals `hd_cause[i]` for bits 0 to 5 and bit 12. Every other bit equals `hd_cause[i]` AND bit i of the status register.
- R2: `retire` is high exactly when `hd_valid` is high, `buf_empty` is low and `rst` is low.
- R3: `trap_take` is high exactly when `retire` is high and any bit of `mcause` is set. `trap_redo` is high exactly when any of `mcause[4:0]` is set.
- R4: `wb_en` equals `retire` AND NOT (`trap_take` AND `trap_redo`). `clear` equals `rst` OR `trap_take`.
- R5: The register indices are: status 0, saved status 1, saved PC 2, saved delayed PC 3, cause 4, trap data 5, FP flags 6, general 7. When `wb_en`, `hd_to_spr` and no higher-priority load apply, register `hd_dst` takes `hd_data` at the next edge.
- R6: When `wb_en` is high and the FP flag register (index 6) is not the write target, the flag register keeps bits 31..5 and ORs the unmasked `hd_cause[11:7]` into bits 4..0.
- R7: A clock edge with `rst` high loads 1 into the cause register and 0 into every other special register.
- R8: On `trap_take`, status is loaded with 0, cause is loaded with `mcause` and trap data is loaded with `hd_edata`.
- R9: On `trap_take`, saved status is loaded with the old status if `trap_redo`. Otherwise it is loaded with the status value produced by this cycle's writeback update.
- R10: On `trap_take`, saved PC is loaded with `hd_pc` if `trap_redo`, else with `hd_npc`. Saved delayed PC is loaded with `hd_dpc` if `trap_redo`, else with `hd_ndpc`.
- R11: `rst` takes priority over `trap_take`, which takes priority over the writeback update for the registers that the interrupt loads.
- R12: Writes to indices 8 and above change no register. Reads at those indices return 0.
- R13: `rd_data` returns the register at `rd_idx` in the same cycle, and every decision output follows its inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also blocks retirement |
| hd_valid | input | 1 | Head entry has completed |
| buf_empty | input | 1 | Reorder buffer holds no entries |
| hd_cause | input | 32 | Raw cause bits of the head entry |
| hd_to_spr | input | 1 | Head entry writes a special register |
| hd_dst | input | 5 | Destination special register index |
| hd_data | input | 32 | Result word of the head entry |
| hd_edata | input | 32 | Trap data of the head entry |
| hd_pc | input | 32 | PC of the head entry |
| hd_npc | input | 32 | PC following the head entry |
| hd_dpc | input | 32 | Delayed PC of the head entry |
| hd_ndpc | input | 32 | Delayed PC following the head entry |
| rd_idx | input | 5 | Read index into the special registers |
| rd_data | output | 32 | Special register at `rd_idx` |
| retire | output | 1 | Head entry commits (acceptance) |
| wb_en | output | 1 | Head entry result is written |
| trap_take | output | 1 | Interrupt taken; rollback |
| trap_redo | output | 1 | Pending interrupt is redo-class |
| clear | output | 1 | Flush request |
| mcause | output | 32 | Cause bits after status gating |

## Verification
On every cycle the assertions check several properties. No gated cause bit survives a zero status word. No interrupt is taken without retirement. A redo-class interrupt never writes back, and every interrupt requests a flush. They also check the register side: an interrupt leaves status at zero and the gated cause in the cause register, a redo-class interrupt saves the prior status, a plain special-register write lands, and set flag bits stay set. Only the bench's scenarios show the remaining behaviour, which its cycle-by-cycle model checks. That covers the choice between the two PC pairs, the saved status seeing a same-cycle write to status, reset overriding a pending interrupt, ignored out-of-range indices, and the flag bits collected only on writeback.

// File: rtl/reu_pkg.sv
package reu_pkg;
  // Special register indices. The trap and reset logic decodes these.
  localparam int SPR_STATUS = 0;
  localparam int SPR_SSTAT  = 1;
  localparam int SPR_EPC    = 2;
  localparam int SPR_EDPC   = 3;
  localparam int SPR_CAUSE  = 4;
  localparam int SPR_EDATA  = 5;
  localparam int SPR_FLAGS  = 6;
  localparam int SPR_GEN    = 7;
  localparam int SPR_COUNT  = 8;
endpackage

// File: rtl/reu_cause_gate.sv
module reu_cause_gate #(
  parameter int XW       = 32,
  parameter int NLOCK_LO = 6,   // bits below this are always enabled
  parameter int FREE_BIT = 12   // one more always-enabled bit
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [XW-1:0] raw_cause,
  input  logic [XW-1:0] status,
  output logic [XW-1:0] mcause
);
  localparam logic [XW-1:0] LOCK_MASK =
    (XW'(1) << NLOCK_LO) - XW'(1) | (XW'(1) << FREE_BIT);

  for (genvar i = 0; i < XW; i++) begin : g_bit
    if (i < NLOCK_LO || i == FREE_BIT) begin : g_fixed
      assign mcause[i] = raw_cause[i];
    end else begin : g_gated
      assign mcause[i] = raw_cause[i] & status[i];
    end
  end

  // R1: with status all zero only the always-enabled bits can survive
  p_gated_bits_r1: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |-> ((mcause & ~LOCK_MASK) == '0));
endmodule

// File: rtl/reu_retire_ctl.sv
module reu_retire_ctl #(
  parameter int XW    = 32,
  parameter int NREDO = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hd_valid,
  input  logic          buf_empty,
  input  logic [XW-1:0] mcause,
  output logic          retire,
  output logic          trap_take,
  output logic          trap_redo,
  output logic          wb_en,
  output logic          clear
);
  logic any_cause;

  assign retire    = hd_valid && !buf_empty && !rst;
  assign any_cause = |mcause;
  assign trap_redo = |mcause[NREDO-1:0];
  assign trap_take = retire && any_cause;
  assign wb_en     = retire && !(trap_take && trap_redo);
  assign clear     = rst || trap_take;

  p_retire_gate_r2: assert property (@(posedge clk) disable iff (rst)
    retire |-> (hd_valid && !buf_empty));
  p_trap_needs_retire_r3: assert property (@(posedge clk) disable iff (rst)
    trap_take |-> (retire && mcause != '0));
  p_redo_blocks_wb_r4: assert property (@(posedge clk) disable iff (rst)
    (trap_take && trap_redo) |-> !wb_en);
  p_trap_flushes_r4: assert property (@(posedge clk) disable iff (rst)
    trap_take |-> clear);
endmodule

// File: rtl/reu_spr_file.sv
module reu_spr_file
  import reu_pkg::*;
#(
  parameter int XW   = 32,
  parameter int IW   = 5,
  parameter int NSPR = SPR_COUNT,
  parameter int FLO  = 7,   // lowest cause bit collected into the flags
  parameter int FW   = 5    // number of flag bits
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trap_take,
  input  logic          trap_redo,
  input  logic          wb_en,
  input  logic          to_spr,
  input  logic [IW-1:0] dst,
  input  logic [XW-1:0] wdata,
  input  logic [XW-1:0] edata,
  input  logic [XW-1:0] pc,
  input  logic [XW-1:0] npc,
  input  logic [XW-1:0] dpc,
  input  logic [XW-1:0] ndpc,
  input  logic [XW-1:0] mcause,
  input  logic [XW-1:0] raw_cause,
  input  logic [IW-1:0] rd_idx,
  output logic [XW-1:0] rd_data,
  output logic [XW-1:0] status
);
  localparam int SW = (NSPR > 1) ? $clog2(NSPR) : 1;

  logic [XW-1:0] regs [NSPR];
  logic [XW-1:0] upd  [NSPR];
  logic [XW-1:0] nxt  [NSPR];

  // Writeback update: addressed write, or flag accumulation.
  always_comb begin
    for (int k = 0; k < NSPR; k++) begin
      upd[k] = regs[k];
      if (wb_en) begin
        if (to_spr && dst == IW'(k)) begin
          upd[k] = wdata;
        end else if (k == SPR_FLAGS) begin
          upd[k][FW-1:0] = regs[k][FW-1:0] | raw_cause[FLO +: FW];
        end
      end
    end
  end

  // Priority: reset, then interrupt loads, then writeback update.
  always_comb begin
    for (int k = 0; k < NSPR; k++) begin
      nxt[k] = upd[k];
      if (rst) begin
        nxt[k] = (k == SPR_CAUSE) ? XW'(1) : '0;
      end else if (trap_take) begin
        if (k == SPR_STATUS)     nxt[k] = '0;
        else if (k == SPR_SSTAT) nxt[k] = trap_redo ? regs[SPR_STATUS] : upd[SPR_STATUS];
        else if (k == SPR_CAUSE) nxt[k] = mcause;
        else if (k == SPR_EPC)   nxt[k] = trap_redo ? pc : npc;
        else if (k == SPR_EDPC)  nxt[k] = trap_redo ? dpc : ndpc;
        else if (k == SPR_EDATA) nxt[k] = edata;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NSPR; k++) begin
      regs[k] <= nxt[k];
    end
  end

  assign status  = regs[SPR_STATUS];
  assign rd_data = (rd_idx < IW'(NSPR)) ? regs[rd_idx[SW-1:0]] : '0;

  p_reset_init_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs[SPR_CAUSE] == XW'(1) && regs[SPR_STATUS] == '0));
  p_trap_status_r8: assert property (@(posedge clk) disable iff (rst)
    trap_take |=> (regs[SPR_STATUS] == '0));
  p_trap_cause_r8: assert property (@(posedge clk) disable iff (rst)
    trap_take |=> (regs[SPR_CAUSE] == $past(mcause)));
  p_redo_sstat_r9: assert property (@(posedge clk) disable iff (rst)
    (trap_take && trap_redo) |=> (regs[SPR_SSTAT] == $past(regs[SPR_STATUS])));
  p_spr_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wb_en && !trap_take && to_spr && dst < IW'(NSPR))
      |=> (regs[$past(dst[SW-1:0])] == $past(wdata)));
  p_flags_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !(wb_en && to_spr && dst == IW'(SPR_FLAGS))
      |=> ((regs[SPR_FLAGS][FW-1:0] & $past(regs[SPR_FLAGS][FW-1:0]))
           == $past(regs[SPR_FLAGS][FW-1:0])));
endmodule

// File: rtl/reu_top.sv
module reu_top
  import reu_pkg::*;
#(
  parameter int XW       = 32,
  parameter int IW       = 5,
  parameter int NSPR     = SPR_COUNT,
  parameter int NLOCK_LO = 6,
  parameter int FREE_BIT = 12,
  parameter int NREDO    = 5,
  parameter int FLO      = 7,
  parameter int FW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hd_valid,
  input  logic          buf_empty,
  input  logic [XW-1:0] hd_cause,
  input  logic          hd_to_spr,
  input  logic [IW-1:0] hd_dst,
  input  logic [XW-1:0] hd_data,
  input  logic [XW-1:0] hd_edata,
  input  logic [XW-1:0] hd_pc,
  input  logic [XW-1:0] hd_npc,
  input  logic [XW-1:0] hd_dpc,
  input  logic [XW-1:0] hd_ndpc,
  input  logic [IW-1:0] rd_idx,
  output logic [XW-1:0] rd_data,
  output logic          retire,
  output logic          wb_en,
  output logic          trap_take,
  output logic          trap_redo,
  output logic          clear,
  output logic [XW-1:0] mcause
);
  logic [XW-1:0] status;

  reu_cause_gate #(.XW(XW), .NLOCK_LO(NLOCK_LO), .FREE_BIT(FREE_BIT)) u_gate (
    .clk(clk), .rst(rst), .raw_cause(hd_cause), .status(status), .mcause(mcause)
  );

  reu_retire_ctl #(.XW(XW), .NREDO(NREDO)) u_ctl (
    .clk(clk), .rst(rst), .hd_valid(hd_valid), .buf_empty(buf_empty),
    .mcause(mcause), .retire(retire), .trap_take(trap_take),
    .trap_redo(trap_redo), .wb_en(wb_en), .clear(clear)
  );

  reu_spr_file #(.XW(XW), .IW(IW), .NSPR(NSPR), .FLO(FLO), .FW(FW)) u_spr (
    .clk(clk), .rst(rst), .trap_take(trap_take), .trap_redo(trap_redo),
    .wb_en(wb_en), .to_spr(hd_to_spr), .dst(hd_dst), .wdata(hd_data),
    .edata(hd_edata), .pc(hd_pc), .npc(hd_npc), .dpc(hd_dpc), .ndpc(hd_ndpc),
    .mcause(mcause), .raw_cause(hd_cause), .rd_idx(rd_idx),
    .rd_data(rd_data), .status(status)
  );
endmodule

// File: tb/reu_top_tb_top.sv
`timescale 1ns/100ps
module reu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hd_valid = 1'b0, buf_empty = 1'b1, hd_to_spr = 1'b0;
  logic [31:0] hd_cause = '0, hd_data = '0, hd_edata = '0;
  logic [31:0] hd_pc = '0, hd_npc = '0, hd_dpc = '0, hd_ndpc = '0;
  logic [4:0]  hd_dst = '0, rd_idx = '0;
  logic [31:0] rd_data, mcause;
  logic        retire, wb_en, trap_take, trap_redo, clear;

  always #4 clk = ~clk;  // 125 MHz

  reu_top dut_i (
    .clk(clk), .rst(rst), .hd_valid(hd_valid), .buf_empty(buf_empty),
    .hd_cause(hd_cause), .hd_to_spr(hd_to_spr), .hd_dst(hd_dst),
    .hd_data(hd_data), .hd_edata(hd_edata), .hd_pc(hd_pc), .hd_npc(hd_npc),
    .hd_dpc(hd_dpc), .hd_ndpc(hd_ndpc), .rd_idx(rd_idx), .rd_data(rd_data),
    .retire(retire), .wb_en(wb_en), .trap_take(trap_take),
    .trap_redo(trap_redo), .clear(clear), .mcause(mcause)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [31:0] mdl [8];
  bit known = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL [%s] %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gate(logic [31:0] c, logic [31:0] s);
    logic [31:0] m;
    for (int i = 0; i < 32; i++)
      m[i] = (i < 6 || i == 12) ? c[i] : (c[i] & s[i]);
    return m;
  endfunction

  task automatic apply(string tag, logic r, logic v, logic e, logic [31:0] c,
                       logic ts, logic [4:0] d, logic [31:0] dat);
    logic [31:0] m, up [8], nx [8];
    logic ret, take, redo, wb, clr;
    @(negedge clk);
    cyc++;
    rst = r; hd_valid = v; buf_empty = e; hd_cause = c;
    hd_to_spr = ts; hd_dst = d; hd_data = dat;
    hd_pc = 32'h1000 + cyc * 8; hd_npc = hd_pc + 4;
    hd_dpc = hd_pc - 4; hd_ndpc = hd_pc;
    hd_edata = 32'hE000_0000 | cyc;
    #0.5;
    if (known) begin
      m    = gate(c, mdl[0]);
      ret  = v && !e && !r;
      take = ret && (m != 0);
      redo = (m[4:0] != 0);
      wb   = ret && !(take && redo);
      clr  = r || take;
      chk(tag, "R1 mcause", mcause, m);
      chk(tag, "R2 retire", {31'b0, retire}, {31'b0, ret});
      chk(tag, "R3 trap_take", {31'b0, trap_take}, {31'b0, take});
      chk(tag, "R3 trap_redo", {31'b0, trap_redo}, {31'b0, redo});
      chk(tag, "R4 wb_en", {31'b0, wb_en}, {31'b0, wb});
      chk(tag, "R4 clear", {31'b0, clear}, {31'b0, clr});
      for (int k = 0; k < 9; k++) begin
        rd_idx = 5'(k); #0.2;
        chk(tag, $sformatf("R13 read idx %0d", k), rd_data, (k < 8) ? mdl[k] : 32'h0);
      end
      rd_idx = 5'd20; #0.2;
      chk(tag, "R12 read idx 20", rd_data, 32'h0);
      for (int k = 0; k < 8; k++) begin
        up[k] = mdl[k];
        if (wb) begin
          if (ts && d == 5'(k)) up[k] = dat;
          else if (k == 6) up[k][4:0] = mdl[k][4:0] | c[11:7];
        end
      end
    end else begin
      take = 0; redo = 0;
      for (int k = 0; k < 8; k++) up[k] = 'x;
    end
    for (int k = 0; k < 8; k++) nx[k] = up[k];
    if (r) begin
      for (int k = 0; k < 8; k++) nx[k] = (k == 4) ? 32'h1 : 32'h0;
    end else if (take) begin
      nx[0] = 0;
      nx[1] = redo ? mdl[0] : up[0];
      nx[4] = gate(c, mdl[0]);
      nx[2] = redo ? hd_pc : hd_npc;
      nx[3] = redo ? hd_dpc : hd_ndpc;
      nx[5] = hd_edata;
    end
    @(posedge clk); #0.1;
    for (int k = 0; k < 8; k++) mdl[k] = nx[k];
    if (r) known = 1;
  endtask

  initial begin
    apply("R7 reset", 1, 0, 1, 0, 0, 0, 0);
    apply("R7 reset", 1, 1, 0, 32'h4, 0, 0, 0);
    apply("R5 write status", 0, 1, 0, 0, 1, 0, 32'hFFFF_FFFF);
    apply("R8 continue trap", 0, 1, 0, 32'h0010_0000, 0, 0, 0);
    apply("R10 check", 0, 0, 1, 0, 0, 0, 0);
    apply("R5 write status", 0, 1, 0, 0, 1, 0, 32'hFFFF_FFFF);
    apply("R9 redo trap", 0, 1, 0, 32'h0000_0204, 1, 7, 32'h55);
    apply("R10 check", 0, 0, 1, 0, 0, 0, 0);
    apply("R6 masked cause", 0, 1, 0, 32'h0000_0100, 0, 0, 0);
    apply("R6 flags", 0, 1, 0, 32'h0000_0880, 1, 7, 32'h77);
    apply("R2 empty", 0, 1, 1, 32'h1, 0, 0, 0);
    apply("R11 reset wins", 1, 1, 0, 32'h8, 1, 0, 32'h1234);
    apply("R11 continue with status write", 0, 1, 0, 32'h1000, 1, 0, 32'h0000_00F0);
    apply("R9 check", 0, 0, 1, 0, 0, 0, 0);
    apply("R12 write idx 20", 0, 1, 0, 0, 1, 20, 32'hDEAD);
    apply("R12 check", 0, 0, 1, 0, 0, 0, 0);
    for (int t = 0; t < 500; t++) begin
      logic [31:0] c;
      logic [3:0] sel;
      sel = 4'($urandom);
      c = (sel < 9) ? 32'h0 : $urandom & ((sel < 12) ? 32'h0000_1FE0 : 32'hFFFF_FFFF);
      apply("R13 random", ($urandom % 40) == 0, ($urandom % 8) != 0,
            ($urandom % 10) == 0, c, $urandom % 2 == 0,
            ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 8), $urandom);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL [watchdog] R13 run did not finish actual=%0d expected=%0d", cyc, 516);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule